// File: doc/BRIEF.md
# Debounced Static Keyboard Encoder

This block turns a hard-wired keyboard into character codes. The character keys sit in a matrix that is not scanned. Each key closes one column sense line and one row sense line together. Eight column inputs and six row inputs are read in parallel. When any line becomes active, a debounce window of fixed length starts. It does not restart on contact bounce. When the window ends, the lines are sampled once. If the key is still held and exactly one column and one row are active, the two line indices are joined into a 6-bit code and a one-cycle strobe is raised.

Function keys each have a dedicated input. They use a second, independent detector and debounce path, which reports the index of the pressed function key with its own strobe. After a press is resolved, a path stays quiet until all of its lines have been idle for a complete debounce window. A held key therefore never repeats. All key inputs are asynchronous and are synchronised before use.

Top module: `key_encoder`

## Requirements
- R1: After reset, strobe_o and fkey_strobe_o are low, and code_o and fkey_idx_o are zero.
- R2: For a clean press of column c and row r that is held through the window, one strobe is issued with code_o[5:3] = c and code_o[2:0] = r, where c and r are the bit positions of the active lines.
- R3: The matrix strobe rises exactly DB_CYCLES+3 clock cycles after the first cycle in which any line is active. Line bounce inside the window neither restarts the window nor changes this timing.
- R4: If no matrix line is active when the window ends, no strobe is issued.
- R5: A strobe lasts one cycle, and a held key gives only one strobe. A new press is accepted only after all lines have been inactive for DB_CYCLES consecutive cycles. A press that starts earlier gives no strobe.
- R6: If two or more column lines, or two or more row lines, are active when the window ends, no strobe is issued and code_o keeps its previous value.
- R7: A single function key at input bit k gives one fkey_strobe_o pulse with fkey_idx_o = k, timed like the matrix path (DB_CYCLES+3 cycles after the press).
- R8: If two or more function keys are active when the window ends, no function strobe is issued.
- R9: Matrix activity never produces fkey_strobe_o, and function-key activity never produces strobe_o.
- R10: code_o and fkey_idx_o change only in the cycle in which their strobe is high, and hold their value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| col_i | input | NCOL (8) | Column sense lines, active high, asynchronous |
| row_i | input | NROW (6) | Row sense lines, active high, asynchronous |
| fkey_i | input | NFKEY (8) | One line per function key, active high, asynchronous |
| code_o | output | clog2(NCOL)+clog2(NROW) (6) | Latched code, column index in the upper bits |
| strobe_o | output | 1 | One-cycle pulse marking a new code_o |
| fkey_idx_o | output | clog2(NFKEY) (3) | Latched index of the function key |
| fkey_strobe_o | output | 1 | One-cycle pulse marking a new fkey_idx_o |

## Verification
Suppose a debounce controller is left in the wrong phase or its counter is off by some amount. The strobe then moves away from its fixed cycle, so the exact-latency check reports it on the very next press. A controller stuck in the release phase shows up as a missing strobe on the next accepted press. One that leaves that phase too early gives an extra strobe on a re-press that should be rejected. A wrong index encoder or validity test shows on the first strobe, either as a wrong code or as a strobe that should have been suppressed on a multi-line press.

// File: rtl/kd_pkg.sv
package kd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PRESS = 2'd1,
    ST_REL   = 2'd2
  } db_state_e;
endpackage

// File: rtl/kd_sync.sv
module kd_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q[s] <= '0;
        else         q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q[s] <= '0;
        else         q[s] <= q[s-1];
    end
  end

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/kd_onehot_enc.sv
module kd_onehot_enc #(
  parameter int N = 8,
  parameter int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] line_i,
  output logic [W-1:0] idx_o,
  output logic         any_o,
  output logic         one_o
);
  localparam int CW = $clog2(N + 1);
  logic [CW-1:0] cnt;

  always_comb begin
    idx_o = '0;
    cnt   = '0;
    for (int i = 0; i < N; i++) begin
      if (line_i[i]) begin
        idx_o = idx_o | W'(i);
        cnt   = cnt + CW'(1);
      end
    end
    any_o = (cnt != '0);
    one_o = (cnt == CW'(1));
  end
endmodule

// File: rtl/kd_debounce.sv
module kd_debounce
  import kd_pkg::*;
#(
  parameter int DB_CYCLES = 2500000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic any_i,
  input  logic ok_i,
  output logic take_o
);
  localparam int CNTW = $clog2(DB_CYCLES + 1);
  localparam logic [CNTW-1:0] LAST = CNTW'(DB_CYCLES - 1);

  db_state_e       state_q;
  logic [CNTW-1:0] cnt_q;
  logic            expire;

  assign expire = (state_q == ST_PRESS) && (cnt_q == LAST);
  assign take_o = expire && any_i && ok_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (any_i) begin
          state_q <= ST_PRESS;
          cnt_q   <= '0;
        end
        ST_PRESS: begin
          // fixed window, bounce does not restart it
          if (cnt_q == LAST) begin
            state_q <= ST_REL;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + CNTW'(1);
        end
        ST_REL: begin
          if (any_i)              cnt_q <= '0;
          else if (cnt_q == LAST) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
          end else                cnt_q <= cnt_q + CNTW'(1);
        end
        default: begin
          state_q <= ST_IDLE;
          cnt_q   <= '0;
        end
      endcase
    end
  end

  p_cnt_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);

  p_single_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> !take_o);

  p_rel_waits_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_REL && any_i) |=> (state_q == ST_REL));
endmodule

// File: rtl/key_encoder.sv
module key_encoder #(
  parameter int NCOL      = 8,
  parameter int NROW      = 6,
  parameter int NFKEY     = 8,
  parameter int DB_CYCLES = 2500000,
  parameter int SYNC      = 2
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic [NCOL-1:0]                      col_i,
  input  logic [NROW-1:0]                      row_i,
  input  logic [NFKEY-1:0]                     fkey_i,
  output logic [$clog2(NCOL)+$clog2(NROW)-1:0] code_o,
  output logic                                 strobe_o,
  output logic [$clog2(NFKEY)-1:0]             fkey_idx_o,
  output logic                                 fkey_strobe_o
);
  localparam int CW   = $clog2(NCOL);
  localparam int RW   = $clog2(NROW);
  localparam int FW   = $clog2(NFKEY);
  localparam int MW   = NCOL + NROW;

  logic [MW-1:0]    mat_s;
  logic [NFKEY-1:0] fk_s;
  logic [CW-1:0]    col_idx;
  logic [RW-1:0]    row_idx;
  logic [FW-1:0]    fk_idx;
  logic             col_any, col_one, row_any, row_one, fk_any, fk_one;
  logic             mat_take, fk_take;

  kd_sync #(.WIDTH(MW), .STAGES(SYNC)) u_sync_mat (
    .clk_i, .rst_ni, .d_i({col_i, row_i}), .q_o(mat_s));

  kd_sync #(.WIDTH(NFKEY), .STAGES(SYNC)) u_sync_fk (
    .clk_i, .rst_ni, .d_i(fkey_i), .q_o(fk_s));

  kd_onehot_enc #(.N(NCOL), .W(CW)) u_enc_col (
    .line_i(mat_s[MW-1:NROW]), .idx_o(col_idx), .any_o(col_any), .one_o(col_one));

  kd_onehot_enc #(.N(NROW), .W(RW)) u_enc_row (
    .line_i(mat_s[NROW-1:0]), .idx_o(row_idx), .any_o(row_any), .one_o(row_one));

  kd_onehot_enc #(.N(NFKEY), .W(FW)) u_enc_fk (
    .line_i(fk_s), .idx_o(fk_idx), .any_o(fk_any), .one_o(fk_one));

  kd_debounce #(.DB_CYCLES(DB_CYCLES)) u_db_mat (
    .clk_i, .rst_ni, .any_i(col_any | row_any), .ok_i(col_one & row_one),
    .take_o(mat_take));

  kd_debounce #(.DB_CYCLES(DB_CYCLES)) u_db_fk (
    .clk_i, .rst_ni, .any_i(fk_any), .ok_i(fk_one), .take_o(fk_take));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_o        <= '0;
      strobe_o      <= 1'b0;
      fkey_idx_o    <= '0;
      fkey_strobe_o <= 1'b0;
    end else begin
      strobe_o      <= mat_take;
      fkey_strobe_o <= fk_take;
      if (mat_take) code_o     <= {col_idx, row_idx};
      if (fk_take)  fkey_idx_o <= fk_idx;
    end
  end

  p_strobe_single_line_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |-> $past(col_one && row_one));

  p_fstrobe_single_key_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fkey_strobe_o |-> $past(fk_one));

  p_code_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(code_o) |-> strobe_o);

  p_fidx_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(fkey_idx_o) |-> fkey_strobe_o);

  p_strobe_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |=> !strobe_o);
endmodule

// File: tb/key_encoder_tb.sv
`timescale 1ns/1ps
module key_encoder_tb;
  localparam int DB = 16;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] col_i = '0;
  logic [5:0] row_i = '0;
  logic [7:0] fkey_i = '0;
  logic [5:0] code_o;
  logic       strobe_o;
  logic [2:0] fkey_idx_o;
  logic       fkey_strobe_o;

  key_encoder #(.NCOL(8), .NROW(6), .NFKEY(8), .DB_CYCLES(DB), .SYNC(2)) u_dut (
    .clk_i, .rst_ni, .col_i, .row_i, .fkey_i,
    .code_o, .strobe_o, .fkey_idx_o, .fkey_strobe_o);

  always #2 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0, cyc = 0, press_cyc = 0, fpress_cyc = 0;
  int n_str = 0, n_fstr = 0;
  string cur_req = "R1";
  logic [5:0] exp_code[$];
  logic [2:0] exp_fk[$];

  always @(posedge clk_i) cyc++;

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [2:0] enc(logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return 3'(i);
    return 3'd0;
  endfunction

  // monitor / scoreboard
  always @(negedge clk_i) if (rst_ni) begin
    if (strobe_o) begin
      n_str++;
      if (exp_code.size() == 0) chk(0, {cur_req, " unexpected strobe"}, 1, 0);
      else begin
        logic [5:0] e;
        e = exp_code.pop_front();
        chk(code_o == e, {cur_req, " code R2"}, code_o, e);
        chk(cyc - press_cyc == DB + 3, "R3 latency", cyc - press_cyc, DB + 3);
      end
    end
    if (fkey_strobe_o) begin
      n_fstr++;
      if (exp_fk.size() == 0) chk(0, {cur_req, " unexpected fstrobe"}, 1, 0);
      else begin
        logic [2:0] e;
        e = exp_fk.pop_front();
        chk(fkey_idx_o == e, {cur_req, " fidx R7"}, fkey_idx_o, e);
        chk(cyc - fpress_cyc == DB + 3, "R7 latency", cyc - fpress_cyc, DB + 3);
      end
    end
  end

  task automatic mat_press(logic [7:0] c, logic [5:0] r, int hold, bit exp);
    @(negedge clk_i);
    press_cyc = cyc;
    if (exp) exp_code.push_back({enc(c), enc({2'b00, r})});
    col_i = c; row_i = r;
    repeat (hold) @(negedge clk_i);
    col_i = '0; row_i = '0;
    repeat (DB + 8) @(negedge clk_i);
    chk(exp_code.size() == 0, {cur_req, " pending"}, exp_code.size(), 0);
  endtask

  task automatic fk_press(logic [7:0] k, int hold, bit exp);
    @(negedge clk_i);
    fpress_cyc = cyc;
    if (exp) exp_fk.push_back(enc(k));
    fkey_i = k;
    repeat (hold) @(negedge clk_i);
    fkey_i = '0;
    repeat (DB + 8) @(negedge clk_i);
    chk(exp_fk.size() == 0, {cur_req, " fpending"}, exp_fk.size(), 0);
  endtask

  task automatic finish_run();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int s0, f0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk(strobe_o == 0, "R1 strobe", strobe_o, 0);
    chk(fkey_strobe_o == 0, "R1 fstrobe", fkey_strobe_o, 0);
    chk(code_o == 0, "R1 code", code_o, 0);
    chk(fkey_idx_o == 0, "R1 fidx", fkey_idx_o, 0);

    // R2 clean presses, several patterns
    cur_req = "R2";
    mat_press(8'b0000_0100, 6'b00_1000, DB + 6, 1);
    mat_press(8'b1000_0000, 6'b10_0000, DB + 6, 1);
    mat_press(8'b0000_0001, 6'b00_0001, DB + 6, 1);
    mat_press(8'b0010_0000, 6'b00_0010, DB + 6, 1);

    // R3 bounce inside the window keeps timing
    cur_req = "R3";
    @(negedge clk_i);
    press_cyc = cyc;
    exp_code.push_back({3'd6, 3'd4});
    for (int i = 0; i < 3; i++) begin
      col_i = 8'b0100_0000; row_i = 6'b01_0000;
      repeat (2) @(negedge clk_i);
      col_i = '0; row_i = '0;
      @(negedge clk_i);
    end
    col_i = 8'b0100_0000; row_i = 6'b01_0000;
    repeat (DB + 6) @(negedge clk_i);
    col_i = '0; row_i = '0;
    repeat (DB + 8) @(negedge clk_i);
    chk(exp_code.size() == 0, "R3 pending", exp_code.size(), 0);

    // R4 released before window end
    cur_req = "R4";
    s0 = n_str;
    mat_press(8'b0000_1000, 6'b00_0100, DB / 2, 0);
    chk(n_str == s0, "R4 no strobe", n_str - s0, 0);

    // R5 held key no repeat; early re-press rejected
    cur_req = "R5";
    s0 = n_str;
    @(negedge clk_i);
    press_cyc = cyc;
    exp_code.push_back({3'd1, 3'd2});
    col_i = 8'b0000_0010; row_i = 6'b00_0100;
    repeat (3 * DB) @(negedge clk_i);
    col_i = '0; row_i = '0;
    repeat (4) @(negedge clk_i);
    col_i = 8'b0000_0010; row_i = 6'b00_0100;
    repeat (2 * DB) @(negedge clk_i);
    col_i = '0; row_i = '0;
    repeat (DB + 8) @(negedge clk_i);
    chk(n_str == s0 + 1, "R5 one strobe", n_str - s0, 1);
    mat_press(8'b0000_0010, 6'b00_0100, DB + 6, 1);
    chk(n_str == s0 + 2, "R5 accepted after idle", n_str - s0, 2);

    // R6 multi-line presses ignored, code kept
    cur_req = "R6";
    s0 = n_str;
    mat_press(8'b0000_1100, 6'b00_0010, DB + 6, 0);
    mat_press(8'b0001_0000, 6'b00_0011, DB + 6, 0);
    chk(n_str == s0, "R6 no strobe", n_str - s0, 0);
    chk(code_o == {3'd1, 3'd2}, "R6/R10 code kept", code_o, {3'd1, 3'd2});

    // R7 function keys
    cur_req = "R7";
    fk_press(8'b0010_0000, DB + 6, 1);
    fk_press(8'b0000_0001, DB + 6, 1);
    fk_press(8'b1000_0000, DB + 6, 1);
    chk(fkey_idx_o == 3'd7, "R10 fidx held", fkey_idx_o, 7);

    // R8 two function keys
    cur_req = "R8";
    f0 = n_fstr;
    fk_press(8'b0001_0100, DB + 6, 0);
    chk(n_fstr == f0, "R8 no fstrobe", n_fstr - f0, 0);

    // R9 path independence
    cur_req = "R9";
    s0 = n_str; f0 = n_fstr;
    mat_press(8'b0000_0100, 6'b00_0001, DB + 6, 1);
    chk(n_fstr == f0, "R9 no fstrobe", n_fstr - f0, 0);
    fk_press(8'b0000_1000, DB + 6, 1);
    chk(n_str == s0 + 1, "R9 no strobe", n_str - s0, 1);
    chk(code_o == {3'd2, 3'd0}, "R10 code held", code_o, {3'd2, 3'd0});

    finish_run();
  end
endmodule